// File: doc/BRIEF.md
# Supply Supervisor with Reset Hold

This block watches the supply rail of a battery-backed memory through two digital comparator outputs. One says whether the rail is inside its operating tolerance. The other says whether the rail is above the lower switchover level, where the backup source takes over. Both outputs arrive with no fixed timing relation to the block clock. From them the block produces three outputs. The first is an enable that pulls the open-drain system reset line low. The second is a write-protect flag for the memory core: while it is set, the core ignores its inputs and floats its data outputs. The third is a select that picks the backup energy source.

Reset and write protection apply as soon as the synchronised tolerance input reports a fault. After the rail recovers they stay applied for a fixed hold time, given as a count of clock ticks. In silicon this count stands for about 200 ms. The backup select depends only on the lower comparator. A rail that climbs past the switchover level, but not yet into tolerance, keeps the memory protected.

Top module: `supply_supervisor`

## Requirements
- R1: Within two rising clock edges of `vdd_in_tol_a` going low, `rst_pull_en` is 1.
- R2: `vdd_in_tol_a` may rise and then stay high. Counting that rise, `rst_pull_en` stays 1 for the next `HOLD_CYCLES+1` rising edges and becomes 0 on edge `HOLD_CYCLES+2`.
- R3: `rst_pull_en` is an open-drain enable: 1 means pull the reset line low, 0 means leave the line released. It is 0 only when the rail is in tolerance and the hold has expired.
- R4: `mem_wr_prot` is 1 whenever `rst_pull_en` is 1 or `bkp_sel` is 1. It clears on the same edge on which reset releases.
- R5: `bkp_sel` equals the inverse of `vdd_above_sw_a`, delayed by exactly two rising edges. It does not depend on the hold timer.
- R6: If `vdd_above_sw_a` is high but `vdd_in_tol_a` is low, reset and write protection stay applied however long that lasts.
- R7: A fault seen during the hold clears the hold count. After recovery the full delay of R2 applies again, measured from the new rise.
- R8: While `rst_n` is low on a rising edge, all three outputs are 1 after that edge. After `rst_n` rises, the full hold of R2 is served before reset releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| vdd_in_tol_a | input | 1 | Asynchronous comparator: 1 = rail within operating tolerance |
| vdd_above_sw_a | input | 1 | Asynchronous comparator: 1 = rail above the switchover level |
| rst_pull_en | output | 1 | 1 = drive the open-drain reset line low |
| mem_wr_prot | output | 1 | 1 = memory core write protected, inputs ignored, outputs floated |
| bkp_sel | output | 1 | 1 = select backup energy source |

## Verification
A hold counter that is stuck or restarts badly shows up at `rst_pull_en`. Reset then releases on some edge other than edge `HOLD_CYCLES+2` after the rise, so the bench samples the edge before and the release edge itself. A missed restart after a one-cycle dip releases reset early, within one hold period. A synchroniser stage too many or too few moves both `rst_pull_en` and `bkp_sel` by one edge, and the two-edge latency checks catch that. A protect flag decoded from the wrong threshold shows within a few cycles in the sequence where only the switchover comparator recovers.

// File: rtl/supply_supervisor_pkg.sv
// Shared types for the supply supervisor.
// Assumes: nothing beyond IEEE 1800-2017.
package supply_supervisor_pkg;

    // State of the post-recovery reset hold.
    typedef enum logic {
        HOLD_BUSY = 1'b1,
        HOLD_DONE = 1'b0
    } hold_state_t;

    // Number of flops in each comparator synchroniser.
    localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/supply_sync.sv
// Multi-bit, multi-stage synchroniser for asynchronous comparator levels.
// Assumes: every bit is a slow level with no relation to the other bits,
//          so bits are synchronised independently.
module supply_sync #(
    parameter int unsigned WIDTH   = 2,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din_a,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage samples the asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= din_a;
                end
            end else begin : g_next
                // Later stages settle any metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/supply_hold_timer.sv
// Hold timer: keeps 'busy' high while 'fault' is high and for HOLD_CYCLES
// clocks after it falls. A new fault restarts the whole count.
// Assumes: 'fault' is already synchronous to clk; HOLD_CYCLES >= 1.
module supply_hold_timer
    import supply_supervisor_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 20_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault,
    output logic busy
);
    localparam int unsigned CW = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt;
    hold_state_t   state;

    // Count clean cycles after a fault; restart on any new fault.
    always_ff @(posedge clk) begin
        if (!rst_n || fault) begin
            cnt   <= '0;
            state <= HOLD_BUSY;
        end else if (state == HOLD_BUSY) begin
            if (cnt == LAST) state <= HOLD_DONE;
            else             cnt   <= cnt + 1'b1;
        end
    end

    assign busy = (state == HOLD_BUSY);

    // R2: the count never runs past its terminal value.
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R2: the hold ends only after a full count with no fault in between.
    p_full_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(cnt) == LAST && !$past(fault)));

    // R7: a fault always brings the timer back to a busy, zeroed state.
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (busy && cnt == '0));
endmodule

// File: rtl/supply_supervisor.sv
// Supply supervisor top. Synchronises the two comparator levels and then:
// applies reset and write protection on an out-of-tolerance rail, holds
// them for HOLD_CYCLES after recovery, and selects the backup source
// below the switchover level.
// Assumes: comparators are glitch-filtered levels; rst_pull_en feeds an
//          open-drain pad whose pull-down is enabled while it is 1.
module supply_supervisor
    import supply_supervisor_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 20_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vdd_in_tol_a,
    input  logic vdd_above_sw_a,
    output logic rst_pull_en,
    output logic mem_wr_prot,
    output logic bkp_sel
);
    logic [1:0] cmp_sync;
    logic       in_tol;
    logic       above_sw;
    logic       hold_busy;

    // Both comparators reset to "rail low" so the block starts safe.
    supply_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b00)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din_a ({vdd_above_sw_a, vdd_in_tol_a}),
        .dout  (cmp_sync)
    );

    assign in_tol   = cmp_sync[0];
    assign above_sw = cmp_sync[1];

    supply_hold_timer #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .fault (!in_tol),
        .busy  (hold_busy)
    );

    // Output decode: a fault acts at once, the hold stretches the release.
    always_comb begin
        rst_pull_en = hold_busy || !in_tol;
        bkp_sel     = !above_sw;
        mem_wr_prot = rst_pull_en || bkp_sel;
    end

    // R1: an out-of-tolerance rail always drives reset.
    p_fault_resets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_tol |-> rst_pull_en);

    // R3: reset releases only from a rail that was in tolerance last cycle.
    p_release_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_pull_en) |-> (in_tol && $past(in_tol)));

    // R6: the switchover comparator alone never lifts protection.
    p_upper_gates_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (above_sw && !in_tol) |-> mem_wr_prot);

    // R4: the protect flag drops only together with the reset release.
    p_prot_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr_prot) |-> !rst_pull_en && !bkp_sel);
endmodule

// File: tb/supply_supervisor_tb.sv
module supply_supervisor_tb;
    localparam int unsigned HOLD = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tol = 1'b0;
    logic sw = 1'b0;
    logic rst_o, wp_o, bk_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    supply_supervisor #(.HOLD_CYCLES(HOLD)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .vdd_in_tol_a   (tol),
        .vdd_above_sw_a (sw),
        .rst_pull_en    (rst_o),
        .mem_wr_prot    (wp_o),
        .bkp_sel        (bk_o)
    );

    // Vector: {tol, sw, cycles, exp_rst, exp_wp, exp_bk}
    typedef struct packed {
        logic       t;
        logic       s;
        logic [7:0] n;
        logic       er;
        logic       ew;
        logic       eb;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 8'd30, 1'b0, 1'b0, 1'b0},  // R3 power-up done, line released
        '{1'b0, 1'b1, 8'd3,  1'b1, 1'b1, 1'b0},  // R1 upper lost
        '{1'b0, 1'b0, 8'd3,  1'b1, 1'b1, 1'b1},  // R5 below switchover
        '{1'b0, 1'b1, 8'd3,  1'b1, 1'b1, 1'b0},  // R6 only switchover back
        '{1'b0, 1'b1, 8'd40, 1'b1, 1'b1, 1'b0},  // R6 long stay
        '{1'b1, 1'b1, 8'd10, 1'b1, 1'b1, 1'b0},  // R2 still holding
        '{1'b1, 1'b1, 8'd20, 1'b0, 1'b0, 1'b0},  // R2 released
        '{1'b1, 1'b0, 8'd3,  1'b0, 1'b1, 1'b1},  // R4 backup forces protect
        '{1'b1, 1'b1, 8'd3,  1'b0, 1'b0, 1'b0}   // R4 protect clears
    };

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        wait_n(3);
        // R8: outputs during block reset
        chk("R8", rst_o, 1'b1, "rst in reset");
        chk("R8", wp_o,  1'b1, "wp in reset");
        chk("R8", bk_o,  1'b1, "bk in reset");
        tol = 1'b1; sw = 1'b1;
        wait_n(2);
        rst_n = 1'b1;
        // R8: full hold after reset release (inputs already high)
        wait_n(HOLD + 1);
        chk("R8", rst_o, 1'b1, "rst before hold end");
        wait_n(1);
        chk("R8", rst_o, 1'b0, "rst at hold end");

        // Table walk
        for (int i = 0; i < NV; i++) begin
            tol = VECS[i].t; sw = VECS[i].s;
            wait_n(int'(VECS[i].n));
            chk("R1-table", rst_o, VECS[i].er, $sformatf("vec %0d rst", i));
            chk("R4-table", wp_o,  VECS[i].ew, $sformatf("vec %0d wp", i));
            chk("R5-table", bk_o,  VECS[i].eb, $sformatf("vec %0d bk", i));
        end

        // R1: latency of fault to reset
        tol = 1'b0;
        wait_n(1);
        chk("R1", rst_o, 1'b0, "one edge after fault");
        wait_n(1);
        chk("R1", rst_o, 1'b1, "two edges after fault");

        // R2: exact release edge
        wait_n(3);
        tol = 1'b1;
        wait_n(HOLD + 1);
        chk("R2", rst_o, 1'b1, "edge HOLD+1");
        chk("R4", wp_o,  1'b1, "wp edge HOLD+1");
        wait_n(1);
        chk("R2", rst_o, 1'b0, "edge HOLD+2");
        chk("R4", wp_o,  1'b0, "wp edge HOLD+2");

        // R7: one-cycle dip during the hold restarts the count
        tol = 1'b0;
        wait_n(4);
        tol = 1'b1;
        wait_n(10);
        tol = 1'b0;
        wait_n(1);
        tol = 1'b1;
        wait_n(HOLD + 1);
        chk("R7", rst_o, 1'b1, "restarted hold edge HOLD+1");
        wait_n(1);
        chk("R7", rst_o, 1'b0, "restarted hold edge HOLD+2");

        // R5: backup latency, independent of hold
        tol = 1'b0;
        wait_n(3);
        sw = 1'b0;
        wait_n(1);
        chk("R5", bk_o, 1'b0, "one edge after switchover drop");
        wait_n(1);
        chk("R5", bk_o, 1'b1, "two edges after switchover drop");
        sw = 1'b1;
        wait_n(2);
        chk("R5", bk_o, 1'b0, "two edges after switchover rise");
        chk("R6", wp_o, 1'b1, "wp with upper still low");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule